// File: doc/BRIEF.md
# Shared Word Memory with Cross-Port Mailbox Interrupts

This block is a two-ported memory of 2048 words that two processors share, one on each side. Either side can read or write any word at any time, and both sides run on one common clock. Only the low 11 bits of each address are used, so an address beyond the array wraps to the same word. The word width is a parameter: 8 or 16 bits.

The two highest words double as mailboxes. When the left side writes the top word, an interrupt is raised toward the right processor, which clears it by reading that word. When the right side writes the word just below the top, an interrupt is raised toward the left processor, which clears it by reading that word. The mailbox words keep their data like any other word; the interrupt is only a side effect of the access. A third, read-only port lets a debugger or monitor look at any word without touching the interrupts. The contention flag is held inactive.

Top module: `dpram_mailbox`

## Requirements
- R1: While reset is low, and after it, both interrupt outputs are 0 and both read-data outputs are 0 until the first read.
- R2: A word written on either port is returned by a later read on either port. Only address bits [10:0] are decoded, so addresses that differ only above bit 10 select the same word.
- R3: A read strobe samples the word at the clock edge and shows it on that port's read data after the edge; the read sees the contents from before any write in the same cycle. Without a read strobe, read data holds its last value.
- R4: When both ports write the same word in one cycle, the left port's data is stored.
- R5: A left-port write to address 0x7FF sets `irq_right` at the next clock edge.
- R6: A right-port read of address 0x7FF clears `irq_right` at the next clock edge.
- R7: A right-port write to address 0x7FE sets `irq_left` at the next clock edge.
- R8: A left-port read of address 0x7FE clears `irq_left` at the next clock edge.
- R9: If one cycle both sets and clears the same interrupt, the interrupt is 1 after the edge.
- R10: The peek port returns the word at `peek_addr` (bits [10:0]) one cycle later and never changes an interrupt.
- R11: Addresses 0x7FE and 0x7FF store and return data like all other words.
- R12: `busy` is always 0.
- R13: An interrupt changes only through its own set and clear accesses; a read of a mailbox by the side that writes it, or a write by the side that reads it, leaves the other interrupt and this one unchanged except as R5 to R8 say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| l_addr | input | ADDR_IN_W | Left-port word address (bits [10:0] used) |
| l_wdata | input | DATA_W | Left-port write data |
| l_we | input | 1 | Left-port write enable |
| l_rd | input | 1 | Left-port read strobe |
| l_rdata | output | DATA_W | Left-port read data, one cycle after the strobe |
| r_addr | input | ADDR_IN_W | Right-port word address (bits [10:0] used) |
| r_wdata | input | DATA_W | Right-port write data |
| r_we | input | 1 | Right-port write enable |
| r_rd | input | 1 | Right-port read strobe |
| r_rdata | output | DATA_W | Right-port read data, one cycle after the strobe |
| peek_addr | input | ADDR_IN_W | Debug peek address |
| peek_data | output | DATA_W | Word at the peek address, one cycle later |
| irq_left | output | 1 | Interrupt toward the left processor |
| irq_right | output | 1 | Interrupt toward the right processor |
| busy | output | 1 | Contention flag, held at 0 |

## Verification
The two functions that can meet in one cycle are the setting of an interrupt by one side's mailbox write and its clearing by the other side's mailbox read, and likewise the two ports writing the same word. The bench forces both in directed cycles and also draws addresses heavily from the two mailbox words and a small window of low words, so random traffic lands both kinds of overlap many times. Each is judged against a bench model in which a same-cycle set wins over a clear and the left write lands last, compared at the falling edge after the access.

// File: rtl/dpram_mailbox_pkg.sv
// Shared definitions for the dual-port mailbox memory.
// Assumes: memory depth is a power of two so address masking is a bit slice.
package dpram_mailbox_pkg;

    // Index of a side; used to pick mailbox roles in generate loops.
    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    // Mailbox hits decoded from one port's access in one cycle.
    typedef struct packed {
        logic wr_top;   // write to highest word
        logic rd_top;   // read of highest word
        logic wr_low;   // write to word below highest
        logic rd_low;   // read of word below highest
    } mbx_hit_t;

endpackage

// File: rtl/mbx_port_decode.sv
// Decodes one port's access: masks the address to the array range and
// flags accesses to the two mailbox words.
// Assumes: DEPTH is a power of two and ADDR_IN_W >= $clog2(DEPTH).
module mbx_port_decode
    import dpram_mailbox_pkg::*;
#(
    parameter int DEPTH     = 2048,
    parameter int ADDR_IN_W = 16,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic [ADDR_IN_W-1:0] addr_in,
    input  logic                 we,
    input  logic                 rd,
    output logic [AW-1:0]        addr_msk,
    output mbx_hit_t             hit
);

    localparam logic [AW-1:0] TOP_A = AW'(DEPTH - 1);
    localparam logic [AW-1:0] LOW_A = AW'(DEPTH - 2);

    // Upper address bits are discarded; the bank wraps.
    generate
        if (ADDR_IN_W > AW) begin : g_wrap
            logic unused_hi;
            assign unused_hi = ^addr_in[ADDR_IN_W-1:AW];
        end
    endgenerate

    assign addr_msk = addr_in[AW-1:0];

    // Flag mailbox accesses from the masked address.
    always_comb begin
        hit.wr_top = we && (addr_msk == TOP_A);
        hit.rd_top = rd && (addr_msk == TOP_A);
        hit.wr_low = we && (addr_msk == LOW_A);
        hit.rd_low = rd && (addr_msk == LOW_A);
    end

endmodule

// File: rtl/mbx_word_array.sv
// Storage array with two write/read ports and a side-effect-free peek.
// Reads are registered (one cycle), return pre-write contents, and hold
// when not strobed. Same-word writes in one cycle: left port is stored.
// Assumes: contents are not reset; only the read registers are.
module mbx_word_array #(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     l_a,
    input  logic [DATA_W-1:0] l_d,
    input  logic              l_we,
    input  logic              l_rd,
    output logic [DATA_W-1:0] l_q,
    input  logic [AW-1:0]     r_a,
    input  logic [DATA_W-1:0] r_d,
    input  logic              r_we,
    input  logic              r_rd,
    output logic [DATA_W-1:0] r_q,
    input  logic [AW-1:0]     p_a,
    output logic [DATA_W-1:0] p_q
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write both ports; the left write is issued last so it wins a tie.
    always_ff @(posedge clk) begin
        if (r_we) mem[r_a] <= r_d;
        if (l_we) mem[l_a] <= l_d;
    end

    // Registered reads for the two processor ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q <= '0;
            r_q <= '0;
        end else begin
            if (l_rd) l_q <= mem[l_a];
            if (r_rd) r_q <= mem[r_a];
        end
    end

    // Peek register, free running, no side effects.
    always_ff @(posedge clk) begin
        p_q <= mem[p_a];
    end

endmodule

// File: rtl/mbx_irq_flag.sv
// One interrupt flag: set and clear pulses, set wins, registered output.
// Assumes: set and clear are single-cycle decoded access strobes.
module mbx_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);

    // Hold the flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_o <= 1'b0;
        else if (set_i) irq_o <= 1'b1;
        else if (clr_i) irq_o <= 1'b0;
    end

endmodule

// File: rtl/dpram_mailbox.sv
// Top: 2048-word dual-port memory shared by two processors with a mailbox
// in the two highest words. Left write of the top word raises irq_right,
// right read of it clears irq_right; right write of the word below the top
// raises irq_left, left read of it clears irq_left.
// Assumes: one common clock; synchronous active-low reset; busy unused.
module dpram_mailbox
    import dpram_mailbox_pkg::*;
#(
    parameter int DEPTH     = 2048,
    parameter int DATA_W    = 16,
    parameter int ADDR_IN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_IN_W-1:0] l_addr,
    input  logic [DATA_W-1:0]    l_wdata,
    input  logic                 l_we,
    input  logic                 l_rd,
    output logic [DATA_W-1:0]    l_rdata,
    input  logic [ADDR_IN_W-1:0] r_addr,
    input  logic [DATA_W-1:0]    r_wdata,
    input  logic                 r_we,
    input  logic                 r_rd,
    output logic [DATA_W-1:0]    r_rdata,
    input  logic [ADDR_IN_W-1:0] peek_addr,
    output logic [DATA_W-1:0]    peek_data,
    output logic                 irq_left,
    output logic                 irq_right,
    output logic                 busy
);

    localparam int AW    = $clog2(DEPTH);
    localparam int SIDES = 2;

    logic [AW-1:0] l_a, r_a, p_a;
    mbx_hit_t      hit [SIDES];
    logic          irq_set [SIDES];
    logic          irq_clr [SIDES];
    logic          irq_q   [SIDES];
    mbx_hit_t      unused_peek_hit;

    mbx_port_decode #(.DEPTH(DEPTH), .ADDR_IN_W(ADDR_IN_W)) u_dec_l (
        .addr_in(l_addr), .we(l_we), .rd(l_rd),
        .addr_msk(l_a), .hit(hit[SIDE_LEFT])
    );

    mbx_port_decode #(.DEPTH(DEPTH), .ADDR_IN_W(ADDR_IN_W)) u_dec_r (
        .addr_in(r_addr), .we(r_we), .rd(r_rd),
        .addr_msk(r_a), .hit(hit[SIDE_RIGHT])
    );

    // Peek address masked through the same decoder; its hits are dropped.
    mbx_port_decode #(.DEPTH(DEPTH), .ADDR_IN_W(ADDR_IN_W)) u_dec_p (
        .addr_in(peek_addr), .we(1'b0), .rd(1'b0),
        .addr_msk(p_a), .hit(unused_peek_hit)
    );

    mbx_word_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .l_a(l_a), .l_d(l_wdata), .l_we(l_we), .l_rd(l_rd), .l_q(l_rdata),
        .r_a(r_a), .r_d(r_wdata), .r_we(r_we), .r_rd(r_rd), .r_q(r_rdata),
        .p_a(p_a), .p_q(peek_data)
    );

    // One flag per receiving side: the opposite side's write of that
    // side's mailbox sets it, the receiving side's read clears it.
    generate
        for (genvar s = 0; s < SIDES; s++) begin : g_irq
            if (s == int'(SIDE_LEFT)) begin : g_left
                always_comb begin
                    irq_set[s] = hit[SIDE_RIGHT].wr_low;
                    irq_clr[s] = hit[SIDE_LEFT].rd_low;
                end
            end else begin : g_right
                always_comb begin
                    irq_set[s] = hit[SIDE_LEFT].wr_top;
                    irq_clr[s] = hit[SIDE_RIGHT].rd_top;
                end
            end
            mbx_irq_flag u_flag (
                .clk(clk), .rst_n(rst_n),
                .set_i(irq_set[s]), .clr_i(irq_clr[s]), .irq_o(irq_q[s])
            );
        end
    endgenerate

    assign irq_left  = irq_q[SIDE_LEFT];
    assign irq_right = irq_q[SIDE_RIGHT];
    assign busy      = 1'b0;

endmodule

// File: rtl/dpram_mailbox_chk.sv
// Checker for the mailbox interrupts, bound to the top module.
// Assumes: synchronous active-low reset on the checked clock.
module dpram_mailbox_chk #(
    parameter int DEPTH     = 2048,
    parameter int DATA_W    = 16,
    parameter int ADDR_IN_W = 16,
    localparam int AW       = $clog2(DEPTH)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_IN_W-1:0] l_addr,
    input logic                 l_we,
    input logic                 l_rd,
    input logic [DATA_W-1:0]    l_rdata,
    input logic [ADDR_IN_W-1:0] r_addr,
    input logic                 r_we,
    input logic                 r_rd,
    input logic [DATA_W-1:0]    r_rdata,
    input logic                 irq_left,
    input logic                 irq_right
);

    localparam logic [AW-1:0] TOP_A = AW'(DEPTH - 1);
    localparam logic [AW-1:0] LOW_A = AW'(DEPTH - 2);

    logic l_top_w, l_low_r, r_top_r, r_low_w;
    assign l_top_w = l_we && (l_addr[AW-1:0] == TOP_A);
    assign l_low_r = l_rd && (l_addr[AW-1:0] == LOW_A);
    assign r_top_r = r_rd && (r_addr[AW-1:0] == TOP_A);
    assign r_low_w = r_we && (r_addr[AW-1:0] == LOW_A);

    // R5
    set_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_top_w |=> irq_right);
    // R6
    clr_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_top_r && !l_top_w) |=> !irq_right);
    // R7
    set_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_low_w |=> irq_left);
    // R8
    clr_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_low_r && !r_low_w) |=> !irq_left);
    // R13
    rise_right_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_right) |-> $past(l_top_w));
    // R13
    hold_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_low_w && !l_low_r) |=> $stable(irq_left));
    // R3
    hold_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_rd && !r_rd) |=> ($stable(l_rdata) && $stable(r_rdata)));

endmodule

bind dpram_mailbox dpram_mailbox_chk #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_IN_W(ADDR_IN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .l_we(l_we), .l_rd(l_rd), .l_rdata(l_rdata),
    .r_addr(r_addr), .r_we(r_we), .r_rd(r_rd), .r_rdata(r_rdata),
    .irq_left(irq_left), .irq_right(irq_right)
);

// File: tb/dpram_mailbox_tb.sv
module dpram_mailbox_tb;

    localparam int DEPTH = 2048;
    localparam int DW    = 16;
    localparam int AWI   = 16;
    localparam int AW    = 11;
    localparam logic [AW-1:0] TOP = 11'h7FF;
    localparam logic [AW-1:0] LOW = 11'h7FE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AWI-1:0] l_addr = '0, r_addr = '0, peek_addr = '0;
    logic [DW-1:0]  l_wdata = '0, r_wdata = '0;
    logic l_we = 0, l_rd = 0, r_we = 0, r_rd = 0;
    logic [DW-1:0] l_rdata, r_rdata, peek_data;
    logic irq_left, irq_right, busy;

    always #5 clk = ~clk;

    dpram_mailbox #(.DEPTH(DEPTH), .DATA_W(DW), .ADDR_IN_W(AWI)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_we(l_we), .l_rd(l_rd), .l_rdata(l_rdata),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_we(r_we), .r_rd(r_rd), .r_rdata(r_rdata),
        .peek_addr(peek_addr), .peek_data(peek_data),
        .irq_left(irq_left), .irq_right(irq_right), .busy(busy)
    );

    // Bench model
    logic [DW-1:0] m_mem [DEPTH];
    logic [DW-1:0] e_l, e_r, e_p;
    logic e_il, e_ir;
    bit   peek_ok = 0;
    int   n_chk = 0, n_fail = 0;
    bit   done = 0;

    function automatic logic [AW-1:0] msk(input logic [AWI-1:0] a);
        return a[AW-1:0];
    endfunction

    function automatic logic irq_next(input logic cur, input logic s, input logic c);
        return s ? 1'b1 : (c ? 1'b0 : cur);
    endfunction

    task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Apply one access cycle, update model at the edge, compare after it.
    task automatic cyc(input string tag,
                       input logic lwe, input logic lrd, input logic [AWI-1:0] la, input logic [DW-1:0] ld,
                       input logic rwe, input logic rrd, input logic [AWI-1:0] ra, input logic [DW-1:0] rd,
                       input logic [AWI-1:0] pa);
        l_we = lwe; l_rd = lrd; l_addr = la; l_wdata = ld;
        r_we = rwe; r_rd = rrd; r_addr = ra; r_wdata = rd;
        peek_addr = pa;
        @(posedge clk);
        if (lrd) e_l = m_mem[msk(la)];
        if (rrd) e_r = m_mem[msk(ra)];
        e_p  = m_mem[msk(pa)];
        e_ir = irq_next(e_ir, lwe && msk(la) == TOP, rrd && msk(ra) == TOP);
        e_il = irq_next(e_il, rwe && msk(ra) == LOW, lrd && msk(la) == LOW);
        if (rwe) m_mem[msk(ra)] = rd;
        if (lwe) m_mem[msk(la)] = ld;
        @(negedge clk);
        chk(tag, "l_rdata", l_rdata, e_l);
        chk(tag, "r_rdata", r_rdata, e_r);
        chk(tag, "irq_left", DW'(irq_left), DW'(e_il));
        chk(tag, "irq_right", DW'(irq_right), DW'(e_ir));
        chk("R12", "busy", DW'(busy), '0);
        if (peek_ok) chk(tag, "peek_data", peek_data, e_p);
    endtask

    task automatic idle(input string tag);
        cyc(tag, 0, 0, '0, '0, 0, 0, '0, '0, '0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        l_we = 0; l_rd = 0; r_we = 0; r_rd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "irq_left", DW'(irq_left), '0);
        chk("R1", "irq_right", DW'(irq_right), '0);
        chk("R1", "l_rdata", l_rdata, '0);
        chk("R1", "r_rdata", r_rdata, '0);
        chk("R12", "busy", DW'(busy), '0);
        e_l = '0; e_r = '0; e_il = 0; e_ir = 0;
        rst_n = 1'b1;
    endtask

    function automatic logic [AWI-1:0] pick_addr(input int unsigned v);
        logic [AWI-1:0] a;
        a = AWI'($urandom);
        case (v % 4)
            0: a[AW-1:0] = TOP;
            1: a[AW-1:0] = LOW;
            default: a[AW-1:0] = AW'($urandom_range(0, 7));
        endcase
        return a;
    endfunction

    initial begin
        #1ms;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        @(negedge clk);
        do_reset();
        // Fill the whole array so every word is known.
        for (int i = 0; i < DEPTH; i++) begin
            l_we = 1; l_rd = 0; l_addr = AWI'(i); l_wdata = '0;
            r_we = 0; r_rd = 0;
            @(negedge clk);
        end
        l_we = 0;
        do_reset();
        peek_ok = 1;
        idle("R1");

        // R2: wrap and cross-port visibility
        cyc("R2", 1, 0, 16'h0805, 16'h1234, 0, 0, '0, '0, '0);
        cyc("R2", 0, 0, '0, '0, 0, 1, 16'h0005, '0, 16'hF805);
        cyc("R2", 0, 0, '0, '0, 1, 0, 16'h0009, 16'hBEEF, '0);
        cyc("R2", 0, 1, 16'h4009, '0, 0, 0, '0, '0, '0);
        // R3: read-before-write and hold without strobe
        cyc("R3", 1, 1, 16'h0009, 16'h5555, 0, 0, '0, '0, '0);
        idle("R3");
        cyc("R3", 0, 1, 16'h0009, '0, 0, 0, '0, '0, '0);
        // R4: same-word write collision, left wins
        cyc("R4", 1, 0, 16'h000A, 16'hAAAA, 1, 0, 16'h080A, 16'hBBBB, '0);
        cyc("R4", 0, 1, 16'h000A, '0, 0, 1, 16'h000A, '0, 16'h000A);
        // R5, R10, R11, R13
        cyc("R5", 1, 0, 16'h07FF, 16'hC0DE, 0, 0, '0, '0, '0);
        cyc("R10", 0, 0, '0, '0, 0, 0, '0, '0, 16'h07FF);
        cyc("R13", 0, 1, 16'h07FF, '0, 1, 0, 16'h07FF, 16'hD00D, '0);
        // R6, R11
        cyc("R6", 0, 0, '0, '0, 0, 1, 16'h07FF, '0, '0);
        idle("R6");
        // R7, R13, R8
        cyc("R7", 0, 0, '0, '0, 1, 0, 16'h07FE, 16'h7E7E, '0);
        cyc("R13", 1, 0, 16'h07FE, 16'h1111, 0, 1, 16'h07FE, '0, 16'h07FE);
        cyc("R8", 0, 1, 16'h07FE, '0, 0, 0, '0, '0, '0);
        cyc("R11", 0, 1, 16'h0FFE, '0, 0, 1, 16'h07FE, '0, '0);
        // R9: set and clear in one cycle
        cyc("R9", 1, 0, 16'h07FF, 16'h9999, 0, 1, 16'h07FF, '0, '0);
        cyc("R9", 0, 0, '0, '0, 1, 0, 16'h07FE, 16'h8888, '0);
        cyc("R9", 0, 1, 16'h07FE, '0, 1, 0, 16'h07FE, 16'h7777, '0);
        cyc("R9", 0, 1, 16'h07FE, '0, 0, 1, 16'hF7FF, '0, '0);

        // Random traffic over mailboxes and a small window (R2, R5..R9)
        for (int n = 0; n < 4000; n++) begin
            cyc("R2", 1'($urandom), 1'($urandom), pick_addr($urandom), DW'($urandom),
                1'($urandom), 1'($urandom), pick_addr($urandom), DW'($urandom),
                pick_addr($urandom));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule